// File: doc/BRIEF.md
# Triggered Waveform Capture Controller

This block sequences sample acquisition for a two-channel sampling oscilloscope. Once armed, it stores decimated signed samples from both channels into two circular buffers that share one write address. The buffer address advances after each stored sample and wraps at the buffer depth. Software arms the controller and then writes a trigger source code. The selectable triggers are immediate, a level crossing on either channel in either direction, and either edge of an asynchronous external trigger line.

When the trigger fires, the controller latches the address of the trigger sample. It then clears the source register to zero, and software polls that register to learn that the trigger has occurred. Capture continues for a programmed number of further decimated samples and then stops. The buffer therefore holds history from before the trigger as well as the requested samples after it. Thresholds, decimation code and post-trigger count come from the surrounding register file and are held steady during a capture.

Top module: `cap_seq`

## Requirements
- R1: After rst_n is released the block is idle: buf_we is low, wr_ptr_cur and wr_ptr_trig are 0, and src_rdata reads 0.
- R2: A cfg_arm pulse while idle starts capture. If cfg_arm and cfg_reset are high in the same cycle, reset wins and no sample is written.
- R3: dec_sel codes 0,1,2,3,4,5 give one write every 1, 8, 64, 1024, 8192, 65536 clocks. Codes 6 and 7 behave as code 0.
- R4: Every write raises buf_we, presents both channel samples, and uses buf_addr equal to wr_ptr_cur. wr_ptr_cur then advances by one modulo 2^ADDR_W.
- R5: Trigger source codes are: 0 none, 1 immediate (the next written sample), 2/3 channel A rising/falling, 4/5 channel B rising/falling, 6/7 external rising/falling.
- R6: A channel counts as "above" when its signed sample is greater than or equal to its signed threshold. A rising crossing is a written sample that is above while the previous written sample of the same capture was not; a falling crossing is the reverse.
- R7: The external line passes through two synchronizer flops before edge detection. An edge acts on the first written sample taken two or more clocks after the line changes. Edges seen while idle are discarded.
- R8: When the trigger fires, wr_ptr_trig takes the trigger sample's address and src_rdata reads 0 from the next cycle on.
- R9: After the trigger sample, exactly trig_delay further samples are written and capture stops. A trig_delay of 0 stops capture right after the trigger sample.
- R10: Writes to the source register take effect only while armed and waiting for a trigger. Writes made while idle or after the trigger are dropped.
- R11: A cfg_reset pulse during capture stops writing at once and returns both pointers and the source register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reset | input | 1 | Pulse: return the sequencer to idle and clear the pointers |
| cfg_arm | input | 1 | Pulse: start buffer writing |
| src_we | input | 1 | Write strobe for the trigger source register |
| src_wdata | input | 3 | Trigger source code to write |
| src_rdata | output | 3 | Trigger source readback; zero once triggered |
| thr_a | input | SMP_W | Channel A threshold, signed |
| thr_b | input | SMP_W | Channel B threshold, signed |
| dec_sel | input | 3 | Decimation code |
| trig_delay | input | DLY_W | Samples to store after the trigger |
| smp_a | input | SMP_W | Channel A sample, signed |
| smp_b | input | SMP_W | Channel B sample, signed |
| ext_trig | input | 1 | Asynchronous external trigger line |
| buf_we | output | 1 | Buffer write enable for both channels |
| buf_addr | output | ADDR_W | Shared buffer write address |
| buf_data_a | output | SMP_W | Channel A write data |
| buf_data_b | output | SMP_W | Channel B write data |
| wr_ptr_cur | output | ADDR_W | Current write address |
| wr_ptr_trig | output | ADDR_W | Address of the trigger sample |

## Verification
Two events can land in the same cycle. In the first, the trigger decision and the end of capture coincide when trig_delay is zero. That case is driven with the falling external edge, and the bench expects exactly one write from the trigger sample onward. In the second, cfg_arm and cfg_reset are raised together, and the bench expects no write at all and both pointers at zero. A reference model in the bench sees only the written data, the thresholds and the moment the external line moved. From these it predicts which written sample should trigger, where the pointers end up, and how many samples follow the trigger, across several decimation codes, every source code and a buffer small enough to wrap.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_POST = 2'd2
  } cap_state_e;

  localparam int DEC_CNT_W = 16;

  localparam logic [2:0] SRC_OFF    = 3'd0;
  localparam logic [2:0] SRC_NOW    = 3'd1;
  localparam logic [2:0] SRC_A_RISE = 3'd2;
  localparam logic [2:0] SRC_A_FALL = 3'd3;
  localparam logic [2:0] SRC_B_RISE = 3'd4;
  localparam logic [2:0] SRC_B_FALL = 3'd5;
  localparam logic [2:0] SRC_X_RISE = 3'd6;
  localparam logic [2:0] SRC_X_FALL = 3'd7;

  // Terminal count of the decimation counter: factor minus one.
  function automatic logic [DEC_CNT_W-1:0] dec_limit(input logic [2:0] sel);
    logic [4:0] sh;
    case (sel)
      3'd1:    sh = 5'd3;
      3'd2:    sh = 5'd6;
      3'd3:    sh = 5'd10;
      3'd4:    sh = 5'd13;
      3'd5:    sh = 5'd16;
      default: sh = 5'd0;
    endcase
    dec_limit = DEC_CNT_W'((32'd1 << sh) - 32'd1);
  endfunction

endpackage

// File: rtl/cap_decim.sv
module cap_decim (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       stb
);
  import cap_pkg::*;

  logic [DEC_CNT_W-1:0] cnt_q, cnt_d, lim;

  assign lim = dec_limit(sel);
  assign stb = run && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || stb) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a strobe is never followed at once by another unless the factor is 1
  a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && lim != '0) |=> (!stb || lim == '0));

endmodule

// File: rtl/cap_trig.sv
module cap_trig #(
  parameter int SMP_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic [SMP_W-1:0] smp_a,
  input  logic [SMP_W-1:0] smp_b,
  input  logic [SMP_W-1:0] thr_a,
  input  logic [SMP_W-1:0] thr_b,
  input  logic             ext_in,
  input  logic [2:0]       code,
  output logic             hit
);
  import cap_pkg::*;

  localparam int NCH = 2;

  logic [NCH-1:0][SMP_W-1:0] smp_v, thr_v;
  logic [NCH-1:0] above, prev_q, prev_d, rise, fall;
  logic           valid_q, valid_d;
  logic [2:0]     sync_q;
  logic           x_rise, x_fall;
  logic           pend_r_q, pend_r_d, pend_f_q, pend_f_d;

  assign smp_v = {smp_b, smp_a};
  assign thr_v = {thr_b, thr_a};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign above[ch] = $signed(smp_v[ch]) >= $signed(thr_v[ch]);
    assign rise[ch]  = valid_q & ~prev_q[ch] &  above[ch];
    assign fall[ch]  = valid_q &  prev_q[ch] & ~above[ch];
  end

  // sync_q[1:0] form the synchronizer, sync_q[2] holds the previous level
  assign x_rise =  sync_q[1] & ~sync_q[2];
  assign x_fall = ~sync_q[1] &  sync_q[2];

  always_comb begin
    prev_d   = prev_q;
    valid_d  = valid_q;
    pend_r_d = pend_r_q;
    pend_f_d = pend_f_q;
    if (clr) begin
      prev_d   = '0;
      valid_d  = 1'b0;
      pend_r_d = 1'b0;
      pend_f_d = 1'b0;
    end else if (stb) begin
      prev_d   = above;
      valid_d  = 1'b1;
      pend_r_d = 1'b0;
      pend_f_d = 1'b0;
    end else begin
      pend_r_d = pend_r_q | x_rise;
      pend_f_d = pend_f_q | x_fall;
    end
  end

  always_comb begin
    case (code)
      SRC_NOW:    hit = 1'b1;
      SRC_A_RISE: hit = rise[0];
      SRC_A_FALL: hit = fall[0];
      SRC_B_RISE: hit = rise[1];
      SRC_B_FALL: hit = fall[1];
      SRC_X_RISE: hit = pend_r_q | x_rise;
      SRC_X_FALL: hit = pend_f_q | x_fall;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      valid_q  <= 1'b0;
      sync_q   <= '0;
      pend_r_q <= 1'b0;
      pend_f_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      valid_q  <= valid_d;
      sync_q   <= {sync_q[1:0], ext_in};
      pend_r_q <= pend_r_d;
      pend_f_q <= pend_f_d;
    end
  end

  // R7: external edges seen while idle are dropped
  a_r7_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pend_r_q && !pend_f_q));

  // R6: no crossing before a first sample of the capture exists
  a_r6_need_prev: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rise == '0 && fall == '0));

endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
  parameter int SMP_W  = 14,
  parameter int ADDR_W = 14,
  parameter int DLY_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reset,
  input  logic              cfg_arm,
  input  logic              src_we,
  input  logic [2:0]        src_wdata,
  output logic [2:0]        src_rdata,
  input  logic [SMP_W-1:0]  thr_a,
  input  logic [SMP_W-1:0]  thr_b,
  input  logic [2:0]        dec_sel,
  input  logic [DLY_W-1:0]  trig_delay,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic              ext_trig,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [SMP_W-1:0]  buf_data_a,
  output logic [SMP_W-1:0]  buf_data_b,
  output logic [ADDR_W-1:0] wr_ptr_cur,
  output logic [ADDR_W-1:0] wr_ptr_trig
);
  import cap_pkg::*;

  cap_state_e        state_q, state_d;
  logic [2:0]        src_q, src_d;
  logic [DLY_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] cur_q, cur_d, trg_q, trg_d;
  logic              active, stb, hit, fire;

  assign active = (state_q != ST_IDLE);

  cap_decim u_decim (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active && !cfg_reset),
    .sel   (dec_sel),
    .stb   (stb)
  );

  cap_trig #(.SMP_W(SMP_W)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!active),
    .stb    (stb),
    .smp_a  (smp_a),
    .smp_b  (smp_b),
    .thr_a  (thr_a),
    .thr_b  (thr_b),
    .ext_in (ext_trig),
    .code   (src_q),
    .hit    (hit)
  );

  assign fire = stb && hit && (state_q == ST_WAIT);

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    rem_d   = rem_q;
    cur_d   = cur_q;
    trg_d   = trg_q;
    if (cfg_reset) begin
      state_d = ST_IDLE;
      src_d   = SRC_OFF;
      rem_d   = '0;
      cur_d   = '0;
      trg_d   = '0;
    end else begin
      if (stb) cur_d = cur_q + 1'b1;
      case (state_q)
        ST_IDLE: if (cfg_arm) state_d = ST_WAIT;
        ST_WAIT: begin
          if (src_we) src_d = src_wdata;
          if (fire) begin
            src_d = SRC_OFF;
            trg_d = cur_q;
            if (trig_delay == '0) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_POST;
              rem_d   = trig_delay;
            end
          end
        end
        ST_POST: if (stb) begin
          rem_d = rem_q - 1'b1;
          if (rem_q == DLY_W'(1)) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_OFF;
      rem_q   <= '0;
      cur_q   <= '0;
      trg_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      rem_q   <= rem_d;
      cur_q   <= cur_d;
      trg_q   <= trg_d;
    end
  end

  assign buf_we      = stb;
  assign buf_addr    = cur_q;
  assign buf_data_a  = smp_a;
  assign buf_data_b  = smp_b;
  assign wr_ptr_cur  = cur_q;
  assign wr_ptr_trig = trg_q;
  assign src_rdata   = src_q;

  // R4: each write advances the shared address by one, wrapping
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> wr_ptr_cur == ADDR_W'($past(wr_ptr_cur) + 1'b1));

  // R4: no write, no movement
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_we && !cfg_reset) |=> $stable(wr_ptr_cur));

  // R8: the source register reads zero after a trigger
  a_r8_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && buf_we && hit) |=> src_rdata == 3'd0);

  // R8: the trigger address is frozen while post-trigger samples are stored
  a_r8_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POST && !cfg_reset) |=> $stable(wr_ptr_trig));

  // R9: the post-trigger count never sits at zero while counting
  a_r9_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POST) |-> rem_q != '0);

  // R11: a reset pulse clears the pointers and halts writing
  a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> (wr_ptr_cur == '0 && wr_ptr_trig == '0 && !buf_we));

endmodule

// File: tb/cap_seq_test.sv
module cap_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SW = 14;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_reset = 1'b0, cfg_arm = 1'b0, src_we = 1'b0;
  logic [2:0]    src_wdata = '0, src_rdata, dec_sel = '0;
  logic [SW-1:0] thr_a = '0, thr_b = '0, smp_a = '0, smp_b = '0;
  logic [DW-1:0] trig_delay = '0;
  logic          ext_trig = 1'b0;
  logic          buf_we;
  logic [AW-1:0] buf_addr, wr_ptr_cur, wr_ptr_trig;
  logic [SW-1:0] buf_data_a, buf_data_b;

  cap_seq #(.SMP_W(SW), .ADDR_W(AW), .DLY_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .cfg_arm(cfg_arm),
    .src_we(src_we), .src_wdata(src_wdata), .src_rdata(src_rdata),
    .thr_a(thr_a), .thr_b(thr_b), .dec_sel(dec_sel), .trig_delay(trig_delay),
    .smp_a(smp_a), .smp_b(smp_b), .ext_trig(ext_trig),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data_a(buf_data_a),
    .buf_data_b(buf_data_b), .wr_ptr_cur(wr_ptr_cur), .wr_ptr_trig(wr_ptr_trig)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int nwr = 0, last_cyc = 0, exp_ptr = 0, mfactor = 1, mcode = 0;
  bit mvalid = 0, pa = 0, pb = 0, btrig = 0, ext_armed = 0, done = 0;
  int btrig_addr = 0, btrig_idx = 0, ext_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int factor_of(input int sel);
    case (sel)
      1: return 8;
      2: return 64;
      3: return 1024;
      4: return 8192;
      5: return 65536;
      default: return 1;
    endcase
  endfunction

  // sample generator: sawtooth on A, its negation on B
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    smp_a = SW'((cyc % 40) * 20 - 400);
    smp_b = SW'(-((cyc % 40) * 20 - 400));
  end

  // write monitor with a trigger model built from the requirements
  initial forever begin
    @(negedge clk);
    if (buf_we) begin
      bit aa, ab, cond;
      aa = $signed(buf_data_a) >= $signed(thr_a);
      ab = $signed(buf_data_b) >= $signed(thr_b);
      chk(int'(buf_addr) == exp_ptr, "R4 address", int'(buf_addr), exp_ptr);
      if (nwr > 0) chk(cyc - last_cyc == mfactor, "R3 spacing", cyc - last_cyc, mfactor);
      case (mcode)
        1: cond = 1;
        2: cond = mvalid && !pa && aa;
        3: cond = mvalid && pa && !aa;
        4: cond = mvalid && !pb && ab;
        5: cond = mvalid && pb && !ab;
        6, 7: cond = ext_armed && (cyc >= ext_cyc + 2);
        default: cond = 0;
      endcase
      if (!btrig && cond) begin
        btrig = 1;
        btrig_addr = int'(buf_addr);
        btrig_idx = nwr;
      end
      pa = aa; pb = ab; mvalid = 1;
      nwr++;
      last_cyc = cyc;
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
  end

  task automatic write_src(input int code);
    src_we = 1'b1;
    src_wdata = 3'(code);
    @(posedge clk);
    mcode = code;
    #2 src_we = 1'b0;
  endtask

  task automatic run_cap(input int sel, input int code, input int ta, input int tb,
                         input int dly, input bit post_poke, input string tag);
    dec_sel = 3'(sel); thr_a = SW'(ta); thr_b = SW'(tb); trig_delay = DW'(dly);
    mfactor = factor_of(sel);
    nwr = 0; mvalid = 0; btrig = 0; mcode = 0; ext_armed = 0;
    @(posedge clk); #2 cfg_arm = 1'b1;
    @(posedge clk); #2 cfg_arm = 1'b0;
    write_src(code);
    if (code == 6 || code == 7) begin
      repeat (3) @(posedge clk);
      #2 ext_trig = (code == 6);
      ext_cyc = cyc;
      ext_armed = 1;
    end
    for (int i = 0; i < 200 * mfactor + 200 && !btrig; i++) @(negedge clk);
    if (post_poke && btrig) begin
      @(posedge clk); #2;
      write_src(3);
      @(negedge clk);
      chk(src_rdata == 3'd0, "R10 write after trigger dropped", int'(src_rdata), 0);
    end
    for (int i = 0; i < (dly + 3) * mfactor + 50 && nwr < btrig_idx + 1 + dly; i++)
      @(negedge clk);
    repeat (3 * mfactor + 5) @(negedge clk);
    chk(btrig, {tag, " R5 trigger seen"}, int'(btrig), 1);
    chk(nwr == btrig_idx + 1 + dly, {tag, " R9 samples after trigger"}, nwr - btrig_idx - 1, dly);
    chk(int'(wr_ptr_trig) == btrig_addr, {tag, " R8 trigger address"}, int'(wr_ptr_trig), btrig_addr);
    chk(src_rdata == 3'd0, {tag, " R8 source reads zero"}, int'(src_rdata), 0);
    chk(int'(wr_ptr_cur) == exp_ptr, {tag, " R4 final pointer"}, int'(wr_ptr_cur), exp_ptr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!buf_we, "R1 no write", int'(buf_we), 0);
    chk(wr_ptr_cur == '0, "R1 cur pointer", int'(wr_ptr_cur), 0);
    chk(wr_ptr_trig == '0, "R1 trig pointer", int'(wr_ptr_trig), 0);
    chk(src_rdata == '0, "R1 source", int'(src_rdata), 0);

    // R10: source write while idle is dropped
    @(posedge clk); #2;
    write_src(5);
    mcode = 0;
    @(negedge clk);
    chk(src_rdata == '0, "R10 idle write dropped", int'(src_rdata), 0);

    run_cap(0, 1, 0, 0, 5, 0, "imm");
    run_cap(0, 2, 0, 0, 20, 1, "A rise wrap");
    run_cap(1, 3, 100, 0, 3, 0, "A fall");
    run_cap(2, 4, 0, -50, 2, 0, "B rise");
    run_cap(0, 5, 0, 37, 0, 0, "B fall zero delay");
    run_cap(1, 6, 0, 0, 4, 0, "R7 ext rise");
    run_cap(0, 7, 0, 0, 0, 0, "R7 ext fall zero delay");
    run_cap(7, 1, 0, 0, 1, 0, "R3 code7");
    run_cap(3, 1, 0, 0, 2, 0, "R3 factor1024");

    // R11: reset in the middle of a capture
    dec_sel = 3'd0; mfactor = 1; nwr = 0; mcode = 0; mvalid = 0;
    @(posedge clk); #2 cfg_arm = 1'b1;
    @(posedge clk); #2 cfg_arm = 1'b0;
    repeat (10) @(posedge clk);
    #2 cfg_reset = 1'b1;
    @(posedge clk); #2 cfg_reset = 1'b0;
    exp_ptr = 0;
    n0 = nwr;
    chk(n0 > 0, "R11 capture was running", n0, 1);
    repeat (10) @(negedge clk);
    chk(nwr == n0, "R11 writing stopped", nwr, n0);
    chk(wr_ptr_cur == '0, "R11 cur pointer cleared", int'(wr_ptr_cur), 0);
    chk(wr_ptr_trig == '0, "R11 trig pointer cleared", int'(wr_ptr_trig), 0);
    chk(src_rdata == '0, "R11 source cleared", int'(src_rdata), 0);

    // R2: arm and reset in one cycle, reset wins
    @(posedge clk); #2 cfg_arm = 1'b1; cfg_reset = 1'b1;
    @(posedge clk); #2 cfg_arm = 1'b0; cfg_reset = 1'b0;
    repeat (10) @(negedge clk);
    chk(nwr == n0, "R2 reset beats arm", nwr, n0);
    chk(wr_ptr_cur == '0, "R2 pointer idle", int'(wr_ptr_cur), 0);

    finish_run();
  end

endmodule